// File: doc/BRIEF.md
# Dual-Phase Pulse Generator with Pin Mode Select

This block drives a single output pin that can carry a pulse train or a static level, or be released to high impedance. In pulse mode the high part and the low part of each period are timed separately. Each comes from its own 16-bit register holding a value n, and the part lasts n+1 ticks. A tick is a one-cycle enable pulse from an outside timebase, so one period spans (high + 1) + (low + 1) ticks. The shortest part is one tick and the longest is 65536 ticks.

A three-bit control field selects what the pin does:
- **Pulse mode:** the pin carries the timed waveform.
- **Drive mode:** the pin is driven to a fixed level.
- **Release mode:** the output enable is dropped.

The host loads both time registers first and then sets the pulse-mode bit. Entering pulse mode always starts a fresh high part. A time value written while the waveform runs is held back until the next high/low boundary, so the current part is never cut short or stretched.

Top module: `dual_phase_pwm`

## Requirements
- R1: In pulse mode, each high part lasts exactly (H+1) ticks, where H is the value last written through `hi_wr`.
- R2: In pulse mode, each low part lasts exactly (L+1) ticks, where L is the value last written through `lo_wr`, so one period is H+L+2 ticks.
- R3: Control bit 2 is the pulse-mode bit. When it is set, `pin_oe` is 1 and `pin_out` follows the waveform, whatever bits 1 and 0 hold.
- R4: With bit 2 clear and bit 1 (drive) set, `pin_oe` is 1 and `pin_out` equals bit 0. This takes effect two clock cycles after the control write.
- R5: With bits 2 and 1 both clear, `pin_oe` is 0 and `pin_out` is 0, whatever bit 0 holds.
- R6: When bit 2 changes from 0 to 1, the waveform starts at the beginning of a full-length high part.
- R7: A time value written while the waveform runs does not change the part in progress. It takes effect from the next high/low boundary.
- R8: The phase counter advances only on cycles where `tick` is 1. With `tick` held at 0, the pin holds its level.
- R9: Bits 7:3 of the control byte have no effect on the pin.
- R10: After reset, `pin_oe` and `pin_out` are both 0, and both time registers hold 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Timebase enable; each high cycle is one tick |
| hi_wr | input | 1 | Write strobe for the high-part time |
| lo_wr | input | 1 | Write strobe for the low-part time |
| time_data | input | 16 | Time value n (part lasts n+1 ticks) |
| ctl_wr | input | 1 | Write strobe for the control byte |
| ctl_data | input | 8 | Control byte: bit 2 pulse mode, bit 1 drive, bit 0 level |
| pin_out | output | 1 | Registered pin value |
| pin_oe | output | 1 | Registered pin output enable |

## Verification
The assertions check several behaviours on every clock cycle:
- The phase counter never passes the length of the part in progress.
- Counting stalls when no tick arrives.
- Entering pulse mode puts the waveform at the start of a high part.
- The loaded lengths stay fixed inside a part.
- A released pin never shows a 1.
- The two static control codes reach the pins two cycles after they are written.

Only the bench scenarios can show the measured part lengths and their sum over many time values. The same holds for a mid-part rewrite showing up in the following part only, for slow tick rates, and for the upper control bits being ignored.

// File: rtl/dpwm_pkg.sv
package dpwm_pkg;
  typedef struct packed {
    logic run;    // bit 2: pulse mode
    logic drive;  // bit 1: drive static level
    logic level;  // bit 0: static level
  } pin_ctl_t;

  localparam int CTL_BITS = $bits(pin_ctl_t);

  typedef enum logic {PH_LOW = 1'b0, PH_HIGH = 1'b1} phase_e;
endpackage

// File: rtl/dpwm_cfg.sv
module dpwm_cfg
  import dpwm_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int CTL_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hi_wr,
  input  logic             lo_wr,
  input  logic [CNT_W-1:0] time_data,
  input  logic             ctl_wr,
  input  logic [CTL_W-1:0] ctl_data,
  output logic [CNT_W-1:0] hi_len,
  output logic [CNT_W-1:0] lo_len,
  output pin_ctl_t         ctl
);
  localparam int NUM_TIMES = 2;

  logic [NUM_TIMES-1:0] wr_vec;
  logic [CNT_W-1:0]     time_q [NUM_TIMES];
  logic                 unused_upper;

  assign wr_vec       = {lo_wr, hi_wr};
  assign unused_upper = ^ctl_data[CTL_W-1:CTL_BITS];

  for (genvar g = 0; g < NUM_TIMES; g++) begin : g_time
    always_ff @(posedge clk) begin
      if (rst) time_q[g] <= '0;
      else if (wr_vec[g]) time_q[g] <= time_data;
    end
  end

  assign hi_len = time_q[0];
  assign lo_len = time_q[1];

  always_ff @(posedge clk) begin
    if (rst) ctl <= '0;
    else if (ctl_wr) ctl <= pin_ctl_t'(ctl_data[CTL_BITS-1:0]);
  end

  p_hold_time_r7: assert property (@(posedge clk) disable iff (rst)
    !hi_wr |=> $stable(hi_len));
endmodule

// File: rtl/dpwm_timer.sv
module dpwm_timer
  import dpwm_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             tick,
  input  logic [CNT_W-1:0] hi_len,
  input  logic [CNT_W-1:0] lo_len,
  output logic             wave
);
  logic             run_q;
  phase_e           ph;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] hi_act;
  logic [CNT_W-1:0] lo_act;
  logic [CNT_W-1:0] cur_len;
  logic             at_end;
  logic             start;

  assign cur_len = (ph == PH_HIGH) ? hi_act : lo_act;
  assign at_end  = tick && (cnt == cur_len);
  assign start   = run && !run_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q  <= 1'b0;
      ph     <= PH_LOW;
      cnt    <= '0;
      hi_act <= '0;
      lo_act <= '0;
    end else begin
      run_q <= run;
      if (start) begin
        ph     <= PH_HIGH;
        cnt    <= '0;
        hi_act <= hi_len;
        lo_act <= lo_len;
      end else if (!run) begin
        ph  <= PH_LOW;
        cnt <= '0;
      end else if (at_end) begin
        ph     <= (ph == PH_HIGH) ? PH_LOW : PH_HIGH;
        cnt    <= '0;
        hi_act <= hi_len;
        lo_act <= lo_len;
      end else if (tick) begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assign wave = (ph == PH_HIGH);

  p_cnt_bound_r1: assert property (@(posedge clk) disable iff (rst)
    run_q |-> (cnt <= cur_len));
  p_start_high_r6: assert property (@(posedge clk) disable iff (rst)
    start |=> (ph == PH_HIGH && cnt == '0));
  p_no_tick_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (run && run_q && !tick) |=> ($stable(ph) && $stable(cnt)));
  p_len_fixed_in_part_r7: assert property (@(posedge clk) disable iff (rst)
    (run && run_q && !at_end) |=> ($stable(hi_act) && $stable(lo_act)));
  p_idle_low_r5: assert property (@(posedge clk) disable iff (rst)
    !run |=> (ph == PH_LOW));
endmodule

// File: rtl/dpwm_pin.sv
module dpwm_pin
  import dpwm_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  pin_ctl_t ctl,
  input  logic     wave,
  output logic     pin_out,
  output logic     pin_oe
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pin_out <= 1'b0;
      pin_oe  <= 1'b0;
    end else if (ctl.run) begin
      pin_out <= wave;
      pin_oe  <= 1'b1;
    end else if (ctl.drive) begin
      pin_out <= ctl.level;
      pin_oe  <= 1'b1;
    end else begin
      pin_out <= 1'b0;
      pin_oe  <= 1'b0;
    end
  end

  p_released_quiet_r5: assert property (@(posedge clk) disable iff (rst)
    !pin_oe |-> !pin_out);
endmodule

// File: rtl/dual_phase_pwm.sv
module dual_phase_pwm
  import dpwm_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int CTL_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             hi_wr,
  input  logic             lo_wr,
  input  logic [CNT_W-1:0] time_data,
  input  logic             ctl_wr,
  input  logic [CTL_W-1:0] ctl_data,
  output logic             pin_out,
  output logic             pin_oe
);
  logic [CNT_W-1:0] hi_len;
  logic [CNT_W-1:0] lo_len;
  pin_ctl_t         ctl;
  logic             wave;

  dpwm_cfg #(.CNT_W(CNT_W), .CTL_W(CTL_W)) u_cfg (
    .clk(clk), .rst(rst), .hi_wr(hi_wr), .lo_wr(lo_wr),
    .time_data(time_data), .ctl_wr(ctl_wr), .ctl_data(ctl_data),
    .hi_len(hi_len), .lo_len(lo_len), .ctl(ctl)
  );

  dpwm_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst(rst), .run(ctl.run), .tick(tick),
    .hi_len(hi_len), .lo_len(lo_len), .wave(wave)
  );

  dpwm_pin u_pin (
    .clk(clk), .rst(rst), .ctl(ctl), .wave(wave),
    .pin_out(pin_out), .pin_oe(pin_oe)
  );

  p_release_code_r5: assert property (@(posedge clk) disable iff (rst)
    (ctl_wr && ctl_data[2:1] == 2'b00) |=> ##1 !pin_oe);
  p_drive_code_r4: assert property (@(posedge clk) disable iff (rst)
    (ctl_wr && ctl_data[2:1] == 2'b01) |=> ##1
      (pin_oe && pin_out == $past(ctl_data[0], 2)));
endmodule

// File: tb/dual_phase_pwm_test.sv
module dual_phase_pwm_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick = 1'b0;
  logic        hi_wr = 1'b0;
  logic        lo_wr = 1'b0;
  logic [15:0] time_data = '0;
  logic        ctl_wr = 1'b0;
  logic [7:0]  ctl_data = '0;
  logic        pin_out;
  logic        pin_oe;

  int checks = 0;
  int errors = 0;
  int tick_per = 1;
  int tph = 0;
  bit finished = 0;

  dual_phase_pwm uut (
    .clk(clk), .rst(rst), .tick(tick), .hi_wr(hi_wr), .lo_wr(lo_wr),
    .time_data(time_data), .ctl_wr(ctl_wr), .ctl_data(ctl_data),
    .pin_out(pin_out), .pin_oe(pin_oe)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    forever begin
      @(negedge clk);
      if (tick_per == 0) tick = 1'b0;
      else begin
        tph = (tph + 1 >= tick_per) ? 0 : tph + 1;
        tick = (tph == 0);
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr_time(input bit is_hi, input int v);
    @(negedge clk);
    time_data = 16'(v);
    if (is_hi) hi_wr = 1'b1; else lo_wr = 1'b1;
    @(negedge clk);
    hi_wr = 1'b0; lo_wr = 1'b0;
  endtask

  task automatic wr_ctl(input int v);
    @(negedge clk);
    ctl_data = 8'(v); ctl_wr = 1'b1;
    @(negedge clk);
    ctl_wr = 1'b0;
  endtask

  // counts a full high run then the following low run; returns at the negedge where the pin rises again
  task automatic run_lengths(output int h, output int l);
    int g = 0;
    while (pin_out !== 1'b1 && g < 3000) begin @(negedge clk); g++; end
    h = 0;
    while (pin_out === 1'b1 && h < 3000) begin h++; @(negedge clk); end
    l = 0;
    while (pin_out === 1'b0 && l < 3000) begin l++; @(negedge clk); end
  endtask

  task automatic setup_run(input int hv, input int lv, input int ctlv);
    wr_ctl(0);
    wr_time(1, hv);
    wr_time(0, lv);
    repeat (3) @(negedge clk);
    wr_ctl(ctlv);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int h, l, n;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10 reset state
    check(pin_oe === 1'b0, "R10 oe", int'(pin_oe), 0);
    check(pin_out === 1'b0, "R10 out", int'(pin_out), 0);
    // R10 time registers at 0: enabling gives 1-tick parts
    tick_per = 1;
    wr_ctl(8'h04);
    run_lengths(h, l);
    check(h == 1, "R10 reset high len", h, 1);
    check(l == 1, "R10 reset low len", l, 1);

    // R1 R2 R6 sweep with a tick on every cycle
    for (int hv = 0; hv < 6; hv++) begin
      for (int lv = 0; lv < 6; lv++) begin
        setup_run(hv, lv, 8'h04);
        run_lengths(h, l);
        check(h == hv + 1, "R6 first high full", h, hv + 1);
        check(l == lv + 1, "R2 low len", l, lv + 1);
        check(pin_oe === 1'b1, "R3 oe in pulse mode", int'(pin_oe), 1);
        run_lengths(h, l);
        check(h == hv + 1, "R1 high len", h, hv + 1);
        check(h + l == hv + lv + 2, "R2 period", h + l, hv + lv + 2);
      end
    end

    // R8 slower timebase: one tick every 3 cycles
    tick_per = 3;
    for (int hv = 0; hv < 3; hv++) begin
      for (int lv = 0; lv < 3; lv++) begin
        setup_run(hv, lv, 8'h04);
        run_lengths(h, l);
        run_lengths(h, l);
        check(h == 3 * (hv + 1), "R8 R1 high len slow tick", h, 3 * (hv + 1));
        check(l == 3 * (lv + 1), "R8 R2 low len slow tick", l, 3 * (lv + 1));
      end
    end

    // R8 no ticks: pin holds
    tick_per = 0;
    setup_run(0, 0, 8'h04);
    repeat (5) @(negedge clk);
    check(pin_out === 1'b1, "R8 start high no tick", int'(pin_out), 1);
    n = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (pin_out !== 1'b1) n++;
    end
    check(n == 0, "R8 held without tick", n, 0);
    tick_per = 1;
    run_lengths(h, l);
    run_lengths(h, l);
    check(h == 1 && l == 1, "R8 resumes", h + l, 2);

    // R3 other bits ignored in pulse mode
    setup_run(2, 1, 8'h07);
    run_lengths(h, l);
    run_lengths(h, l);
    check(h == 3 && l == 2, "R3 ctl 111", h * 10 + l, 32);
    setup_run(2, 1, 8'h05);
    run_lengths(h, l);
    run_lengths(h, l);
    check(h == 3 && l == 2, "R3 ctl 101", h * 10 + l, 32);

    // R7 rewrite of high time while a high part runs
    setup_run(3, 3, 8'h04);
    n = 0;
    while (pin_out !== 1'b1 && n < 100) begin @(negedge clk); n++; end
    time_data = 16'd6; hi_wr = 1'b1;
    n = 1;
    @(negedge clk);
    hi_wr = 1'b0;
    while (pin_out === 1'b1 && n < 100) begin n++; @(negedge clk); end
    check(n == 4, "R7 current high unchanged", n, 4);
    l = 0;
    while (pin_out === 1'b0 && l < 100) begin l++; @(negedge clk); end
    check(l == 4, "R7 low unchanged", l, 4);
    run_lengths(h, l);
    check(h == 7, "R7 next high uses new value", h, 7);
    // R7 rewrite of low time during low part
    while (pin_out !== 1'b0) @(negedge clk);
    wr_time(0, 1);
    run_lengths(h, l);
    check(l == 2, "R7 next low uses new value", l, 2);

    // R4 / R5 static modes
    wr_ctl(8'h02); repeat (2) @(negedge clk);
    check(pin_oe === 1'b1 && pin_out === 1'b0, "R4 drive low", int'({pin_oe, pin_out}), 2);
    wr_ctl(8'h03); repeat (2) @(negedge clk);
    check(pin_oe === 1'b1 && pin_out === 1'b1, "R4 drive high", int'({pin_oe, pin_out}), 3);
    wr_ctl(8'h01); repeat (2) @(negedge clk);
    check(pin_oe === 1'b0 && pin_out === 1'b0, "R5 level bit set released", int'({pin_oe, pin_out}), 0);
    wr_ctl(8'h00); repeat (2) @(negedge clk);
    check(pin_oe === 1'b0 && pin_out === 1'b0, "R5 released", int'({pin_oe, pin_out}), 0);

    // R9 upper control bits ignored
    wr_ctl(8'hFB); repeat (2) @(negedge clk);
    check(pin_oe === 1'b1 && pin_out === 1'b1, "R9 F8|3 drive high", int'({pin_oe, pin_out}), 3);
    wr_ctl(8'hF9); repeat (2) @(negedge clk);
    check(pin_oe === 1'b0 && pin_out === 1'b0, "R9 F8|1 released", int'({pin_oe, pin_out}), 0);
    wr_ctl(8'hFA); repeat (2) @(negedge clk);
    check(pin_oe === 1'b1 && pin_out === 1'b0, "R9 F8|2 drive low", int'({pin_oe, pin_out}), 2);
    wr_ctl(8'h00);
    wr_time(1, 1);
    wr_time(0, 2);
    wr_ctl(8'hFC);
    run_lengths(h, l);
    check(h == 2 && l == 3, "R9 F8|4 pulse", h * 10 + l, 23);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule